// File: doc/BRIEF.md
# Cascaded 2/3 Multi-Modulus Divider

This block divides a fast input clock by a programmable integer and emits one single-cycle pulse per divided period. It is the feedback divider of a fractional-N synthesizer. The divisor is not held in a down-counter. It comes from a chain of divide-by-2/3 cells with one program bit per cell. A modulus-control signal starts at the last active cell and travels back toward the first. Each cell adds at most one extra input cycle per output period. A select input picks five active cells (ratios 32 to 63) or six active cells (ratios 64 to 127).

The divisor word is formed by adding a signed modulator offset to an integer (coarse) count. The sum is registered only at the end of an output period. A sigma-delta modulator can therefore give a new ratio every period, and no period ever mixes two words. The output pulse doubles as the modulator's update enable.

The design is fully synchronous to the input clock and uses per-cell enables instead of ripple clocks. Each cell is a three-state machine:

- `PH_LOW` moves to `PH_HIGH` on an input event.
- `PH_HIGH` moves to `PH_EXTRA` when it swallows, and back to `PH_LOW` otherwise. Swallowing needs both the program bit and the incoming modulus control to be high.
- `PH_EXTRA` always returns to `PH_LOW`.

An inactive cell, and any cell in reset, is held in `PH_LOW`.

Top module: `mmd_divider`

## Requirements
- R1: While `rst` is high at a rising edge, `div_out` is low after that edge, every cell returns to its first phase, and the word and select are loaded continuously. The first pulse follows exactly N rising edges after the last reset edge, where N is the ratio of the inputs present at that last reset edge.
- R2: With `sel_long` = 1 (six active cells), the ratio N is 64 + s, where s is the 6-bit divisor word (range 64 to 127).
- R3: With `sel_long` = 0 (five active cells), N is 32 + s[4:0], and bit 5 of the divisor word has no effect (range 32 to 63).
- R4: The divisor word s is (`coarse_cnt` + `mod_offset`) modulo 64. Here `mod_offset` is a 4-bit two's-complement value from -8 to +7.
- R5: The word and the select are sampled only on the rising edge that ends a period (the edge after which `div_out` is high) and during reset. Changes at any other time leave the running period unchanged.
- R6: `div_out` is high for exactly one input cycle per divided period, and never for two cycles in a row.
- R7: Within one output period each cell divides by 3 at most once. A cell swallows only when its program bit and its incoming modulus control are both high. The last active cell sees its modulus control tied high.
- R8: Back-to-back periods with different ratios run with no lost or extra input cycle. This holds for the extremes 32, 63, 64 and 127 and across switches between five and six cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| sel_long | input | 1 | 1 selects six active cells, 0 selects five |
| coarse_cnt | input | 6 | Integer part of the division word |
| mod_offset | input | 4 | Signed modulator offset added to the coarse count |
| div_out | output | 1 | One-cycle pulse per divided period; modulator update enable |

## Verification
Two things fall on the same edge: the chain wrapping to end a period, and the registering of the next divisor word and select. On that edge the cell that was switched off must reappear in its first phase with the new word in force. The bench provokes this by changing the inputs to unrelated values mid-period and then setting the intended ones before the boundary. The configurations alternate between five and six cells and hit both ends of each range. Each period's length is counted at the output and compared with the ratio computed from the values present at the boundary. A length that matches the mid-period values, or is one cycle off, shows a broken sampling point.

// File: rtl/mmd_pkg.sv
`timescale 1ns/1ps
package mmd_pkg;

    // Phase of one divide-by-2/3 cell within its own output cycle.
    typedef enum logic [1:0] {
        PH_LOW   = 2'd0,
        PH_HIGH  = 2'd1,
        PH_EXTRA = 2'd2
    } cell_phase_e;

endpackage

// File: rtl/mmd_cell.sv
`timescale 1ns/1ps
module mmd_cell
    import mmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic en_in,
    input  logic prog,
    input  logic mc_in,
    output logic en_out,
    output logic mc_out,
    output logic swallow
);

    cell_phase_e st_q;
    cell_phase_e st_d;
    logic        take_extra;

    // A cell stretches its cycle only when both its bit and the control agree.
    assign take_extra = prog & mc_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= PH_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_LOW:   if (en_in) st_d = PH_HIGH;
            PH_HIGH:  if (en_in) st_d = take_extra ? PH_EXTRA : PH_LOW;
            PH_EXTRA: if (en_in) st_d = PH_LOW;
            default:  st_d = PH_LOW;
        endcase
        if (!active) begin
            st_d = PH_LOW;
        end
    end

    // Outputs: wrap enable to the next cell, control back to the previous one.
    always_comb begin
        en_out  = 1'b0;
        mc_out  = 1'b0;
        swallow = 1'b0;
        unique case (st_q)
            PH_LOW: begin
                en_out  = 1'b0;
                mc_out  = 1'b0;
            end
            PH_HIGH: begin
                en_out  = en_in & active & ~take_extra;
                mc_out  = mc_in & active & ~prog;
                swallow = en_in & active & take_extra;
            end
            PH_EXTRA: begin
                en_out  = en_in & active;
                mc_out  = mc_in & active;
            end
            default: begin
                en_out  = 1'b0;
                mc_out  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mmd_word_reg.sv
`timescale 1ns/1ps
module mmd_word_reg #(
    parameter int WORD_W = 6,
    parameter int OFFS_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              sel_in,
    input  logic [WORD_W-1:0] coarse,
    input  logic [OFFS_W-1:0] offset,
    output logic [WORD_W-1:0] word_q,
    output logic              sel_q
);

    localparam int EXT_W = WORD_W - OFFS_W;

    logic [WORD_W-1:0] offs_ext;
    logic [WORD_W-1:0] word_sum;

    assign offs_ext = {{EXT_W{offset[OFFS_W-1]}}, offset};
    assign word_sum = coarse + offs_ext;

    // Loaded through reset and at each period boundary only.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            word_q <= word_sum;
            sel_q  <= sel_in;
        end
    end

endmodule

// File: rtl/mmd_divider.sv
`timescale 1ns/1ps
module mmd_divider #(
    parameter int CELLS_MAX = 6,
    parameter int OFFS_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_long,
    input  logic [CELLS_MAX-1:0] coarse_cnt,
    input  logic [OFFS_W-1:0]    mod_offset,
    output logic                 div_out
);

    localparam int WORD_W     = CELLS_MAX;
    localparam int LAST_LONG  = CELLS_MAX - 1;
    localparam int LAST_SHORT = CELLS_MAX - 2;

    logic [WORD_W-1:0]    word_q;
    logic                 sel_q;
    logic [CELLS_MAX:0]   en_chain;
    logic [CELLS_MAX:0]   mc_chain;
    logic [CELLS_MAX-1:0] cell_active;
    logic [CELLS_MAX-1:0] cell_mc_in;
    logic [CELLS_MAX-1:0] swallow_vec;
    logic                 top_en;
    logic                 boundary;

    mmd_word_reg #(
        .WORD_W (WORD_W),
        .OFFS_W (OFFS_W)
    ) u_word (
        .clk    (clk),
        .rst    (rst),
        .load   (boundary),
        .sel_in (sel_long),
        .coarse (coarse_cnt),
        .offset (mod_offset),
        .word_q (word_q),
        .sel_q  (sel_q)
    );

    assign en_chain[0]         = 1'b1;
    assign mc_chain[CELLS_MAX] = 1'b1;

    for (genvar g = 0; g < CELLS_MAX; g++) begin : g_cell
        if (g == LAST_LONG) begin : g_top
            assign cell_active[g] = sel_q;
            assign cell_mc_in[g]  = mc_chain[g+1];
        end else if (g == LAST_SHORT) begin : g_short_top
            assign cell_active[g] = 1'b1;
            assign cell_mc_in[g]  = ~sel_q | mc_chain[g+1];
        end else begin : g_inner
            assign cell_active[g] = 1'b1;
            assign cell_mc_in[g]  = mc_chain[g+1];
        end

        mmd_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .active  (cell_active[g]),
            .en_in   (en_chain[g]),
            .prog    (word_q[g]),
            .mc_in   (cell_mc_in[g]),
            .en_out  (en_chain[g+1]),
            .mc_out  (mc_chain[g]),
            .swallow (swallow_vec[g])
        );
    end

    // Chain wraps when the last active cell completes; the control reaching
    // the first cell marks the same final input cycle.
    assign top_en   = sel_q ? en_chain[CELLS_MAX] : en_chain[CELLS_MAX-1];
    assign boundary = top_en & mc_chain[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= 1'b0;
        end else begin
            div_out <= boundary;
        end
    end

endmodule

// File: rtl/mmd_chain_chk.sv
`timescale 1ns/1ps
module mmd_chain_chk #(
    parameter int CELLS_MAX = 6,
    parameter int OFFS_W    = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_long,
    input logic [CELLS_MAX-1:0] coarse_cnt,
    input logic [OFFS_W-1:0]    mod_offset,
    input logic                 div_out,
    input logic [CELLS_MAX-1:0] swallow
);

    localparam int LEN_W = CELLS_MAX + 2;

    function automatic logic [LEN_W-1:0] period_of(
        input logic                 sel,
        input logic [CELLS_MAX-1:0] c,
        input logic [OFFS_W-1:0]    o
    );
        logic [CELLS_MAX-1:0] s;
        s = c + CELLS_MAX'(signed'(o));
        if (sel) begin
            return LEN_W'(1 << CELLS_MAX) + LEN_W'(s);
        end
        return LEN_W'(1 << (CELLS_MAX - 1)) + LEN_W'(s[CELLS_MAX-2:0]);
    endfunction

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] exp_q;
    logic [LEN_W-1:0] prev_len;

    always_ff @(posedge clk) begin
        prev_len <= period_of(sel_long, coarse_cnt, mod_offset);
        if (rst) begin
            cnt_q <= '0;
            exp_q <= period_of(sel_long, coarse_cnt, mod_offset);
        end else if (div_out) begin
            cnt_q <= LEN_W'(1);
            exp_q <= prev_len;
        end else begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    AST_RESET_SILENT: assert property (@(posedge clk) rst |=> !div_out); // R1

    AST_PERIOD_LEN: assert property (@(posedge clk) disable iff (rst)
        div_out |-> (cnt_q == exp_q)); // R2

    AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out); // R6

    for (genvar g = 0; g < CELLS_MAX; g++) begin : g_sw
        logic [2:0] sw_cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                sw_cnt <= '0;
            end else if (div_out) begin
                sw_cnt <= {2'b00, swallow[g]};
            end else begin
                sw_cnt <= sw_cnt + {2'b00, swallow[g]};
            end
        end
        AST_SINGLE_SWALLOW: assert property (@(posedge clk) disable iff (rst)
            sw_cnt <= 3'd1); // R7
    end

endmodule

bind mmd_divider mmd_chain_chk #(
    .CELLS_MAX (CELLS_MAX),
    .OFFS_W    (OFFS_W)
) u_chain_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_long   (sel_long),
    .coarse_cnt (coarse_cnt),
    .mod_offset (mod_offset),
    .div_out    (div_out),
    .swallow    (swallow_vec)
);

// File: tb/mmd_divider_bench.sv
`timescale 1ns/1ps
module mmd_divider_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_long = 1'b0;
    logic [5:0] coarse_cnt = '0;
    logic [3:0] mod_offset = '0;
    logic       div_out;

    typedef struct {
        int    len;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int        n_checks = 0;
    int        n_fail   = 0;
    int        cnt      = -1;
    bit        prev_hi  = 1'b0;

    always #4 clk = ~clk;

    mmd_divider u_mmd_divider (
        .clk        (clk),
        .rst        (rst),
        .sel_long   (sel_long),
        .coarse_cnt (coarse_cnt),
        .mod_offset (mod_offset),
        .div_out    (div_out)
    );

    function automatic int ratio_of(bit s, int c, int o);
        int w;
        w = (c + o) & 63;
        return s ? (64 + w) : (32 + (w & 31));
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic apply(bit s, int c, int o);
        sel_long   = s;
        coarse_cnt = 6'(c);
        mod_offset = 4'(o);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Driver: disturb inputs mid-period, then set the next configuration and
    // queue the ratio it must produce for the period after the boundary.
    task automatic step(bit s, int c, int o, string tag);
        repeat (3) @(posedge clk);
        #2 apply(~s, c ^ 21, o + 5);
        repeat (3) @(posedge clk);
        #2 apply(s, c, o);
        exp_q.push_back('{ratio_of(s, c, o), tag});
        do @(negedge clk); while (!div_out);
        @(posedge clk);
        #2;
    endtask

    // Monitor: measure each period at the output and pop the scoreboard.
    always @(negedge clk) begin
        if (rst) begin
            cnt     = -1;
            prev_hi = 1'b0;
        end else begin
            cnt++;
            if (prev_hi) begin
                check(!div_out, "R6", int'(div_out), 0);
            end
            if (div_out) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected pulse", cnt, 0);
                end else begin
                    exp_item_t it;
                    it = exp_q.pop_front();
                    check(cnt == it.len, it.tag, cnt, it.len);
                end
                cnt = 0;
            end
            prev_hi = div_out;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        apply(1'b1, 10, 0);
        @(posedge clk);
        @(negedge clk);
        check(div_out == 1'b0, "R1 reset low", int'(div_out), 0);
        repeat (3) @(posedge clk);
        exp_q.push_back('{ratio_of(1'b1, 10, 0), "R1"});
        #2 rst = 1'b0;

        step(1'b0, 0, 0, "R3 min 32");
        step(1'b0, 31, 0, "R3 max 63");
        step(1'b1, 63, 0, "R7 all cells swallow 127");
        step(1'b1, 0, 0, "R8 switch to 64");
        step(1'b0, 40, 0, "R3 bit5 ignored");
        step(1'b1, 2, -3, "R4 negative wrap");
        step(1'b1, 62, 4, "R4 positive wrap");
        step(1'b0, 21, -2, "R4 short mode");
        step(1'b1, 45, 7, "R2 long mode");
        step(1'b1, 45, -8, "R5 mid-period change");
        step(1'b0, 17, 3, "R8 switch to short");

        // Mid-period reset flushes the running period.
        repeat (5) @(posedge clk);
        #2 rst = 1'b1;
        apply(1'b0, 5, 0);
        exp_q.delete();
        repeat (3) begin
            @(negedge clk);
            check(div_out == 1'b0, "R1 reset low", int'(div_out), 0);
        end
        @(posedge clk);
        #2;
        exp_q.push_back('{ratio_of(1'b0, 5, 0), "R1 after reset"});
        rst = 1'b0;
        step(1'b1, 1, 0, "R2 after reset");

        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule